// File: doc/BRIEF.md
# Dot Matrix Glyph Plotter

The plotter draws one character cell on a bistable dot display that keeps each dot lit or dark until that dot is addressed again. A start request hands over a packed 126-bit glyph image together with a base X/Y coordinate. The block then steps through the 9-column by 14-dot cell. For every dot it issues one point command carrying the dot's coordinate: a write command when the image bit is 1, and an erase command when it is 0. Because every dot is commanded, the whole cell is rewritten, not only its lit dots.

The scan begins at the top-left corner and runs down a column, one row at a time. It then moves to the next column to the right and starts again from the top. Each command is held until the display signals completion. After the last dot the block pulses done and returns to idle. The glyph lookup and character decoding are done elsewhere.

Top module: `glyph_plotter`

## Requirements
- R1: After reset, busy_o, done_o, pt_wr_o and pt_er_o are all low.
- R2: A start_i sampled high while idle captures image_i, base_x_i and base_y_i. From the next cycle busy_o is high and the first point command (column 0, row 0) is presented.
- R3: Points are issued column by column, left to right, with rows taken top to bottom within each column. The dot at column c, row r (row 0 at the top) uses image bit index c*14 + r.
- R4: The point at column c, row r is placed at pt_x_o = base_x + c and pt_y_o = base_y - r. Both are 9-bit values that wrap modulo 512, and a smaller Y lies lower on the screen.
- R5: While a point is issued, exactly one of pt_wr_o and pt_er_o is high. pt_wr_o is high when the dot's image bit is 1, and pt_er_o is high when the bit is 0.
- R6: A presented point command (pt_x_o, pt_y_o, pt_wr_o, pt_er_o) stays unchanged until pt_ack_i is sampled high.
- R7: In the cycle after a point is acknowledged, pt_wr_o and pt_er_o are both low. The next point follows one cycle later.
- R8: After the 126th point is acknowledged, done_o is high for exactly one cycle. In that cycle busy_o, pt_wr_o and pt_er_o are low.
- R9: A start_i arriving while busy is ignored. The running cell keeps its captured image and base coordinate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to plot one cell |
| image_i | input | 126 | Packed glyph image, bit c*14+r for column c, row r |
| base_x_i | input | 9 | X of the cell's top-left dot |
| base_y_i | input | 9 | Y of the cell's top-left dot |
| busy_o | output | 1 | A cell is being plotted |
| done_o | output | 1 | One-cycle pulse after the last point |
| pt_x_o | output | 9 | X of the current point |
| pt_y_o | output | 9 | Y of the current point |
| pt_wr_o | output | 1 | Write (light) the current point |
| pt_er_o | output | 1 | Erase (darken) the current point |
| pt_ack_i | input | 1 | Display completion status, a one-cycle pulse |

## Verification
The bench builds the plotter with its default 9-by-14 cell and 9-bit coordinates. That cell is small enough to check every one of the 126 dot positions for each of several images: all-clear, all-set, alternating, and two arithmetic patterns. Base coordinates are chosen so that X wraps past 511 and Y wraps below 0. Acknowledge latencies of 0 to 3 cycles exercise command holding, and a start pulse injected mid-cell with a different image and base tests that the running cell ignores it.

// File: rtl/glyph_plot_pkg.sv
package glyph_plot_pkg;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_ISSUE = 2'd1,
    PS_GAP   = 2'd2
  } plot_state_t;

  // Column-major packing: column c, row r sits at c*rows + r.
  function automatic int unsigned dot_index(int unsigned col, int unsigned row,
                                            int unsigned rows);
    return col * rows + row;
  endfunction

endpackage

// File: rtl/glyph_scan_ctr.sv
module glyph_scan_ctr #(
  parameter int COLS = 9,
  parameter int ROWS = 14,
  localparam int CLW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           step,
  output logic [CLW-1:0] col,
  output logic [RW-1:0]  row,
  output logic           last
);

  localparam logic [CLW-1:0] COL_MAX = CLW'(COLS - 1);
  localparam logic [RW-1:0]  ROW_MAX = RW'(ROWS - 1);

  logic row_wrap;
  assign row_wrap = (row == ROW_MAX);
  assign last     = row_wrap && (col == COL_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else if (clear) begin
      col <= '0;
      row <= '0;
    end else if (step) begin
      if (row_wrap) begin
        row <= '0;
        col <= last ? '0 : col + 1'b1;
      end else begin
        row <= row + 1'b1;
      end
    end
  end

  // R3: counters never leave the cell
  assert_scan_in_cell_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (row <= ROW_MAX) && (col <= COL_MAX));

  // R3: a step inside a column moves exactly one row down, same column
  assert_row_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !row_wrap) |=> (row == $past(row) + 1'b1) && $stable(col));

endmodule

// File: rtl/glyph_bit_pick.sv
module glyph_bit_pick #(
  parameter int W = 126,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  image,
  input  logic [IW-1:0] idx,
  output logic          dot
);

  assign dot = image[idx];

endmodule

// File: rtl/glyph_cmd_fsm.sv
module glyph_cmd_fsm
  import glyph_plot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  input  logic last,
  output logic capture,
  output logic issue,
  output logic step,
  output logic busy,
  output logic done
);

  plot_state_t state, state_nx;

  assign capture = (state == PS_IDLE) && start;
  assign issue   = (state == PS_ISSUE);
  assign step    = issue && ack;
  assign busy    = (state != PS_IDLE);

  always_comb begin
    state_nx = state;
    unique case (state)
      PS_IDLE:  if (start) state_nx = PS_ISSUE;
      PS_ISSUE: if (ack)   state_nx = last ? PS_IDLE : PS_GAP;
      PS_GAP:              state_nx = PS_ISSUE;
      default:             state_nx = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PS_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_nx;
      done  <= step && last;
    end
  end

  // R8: done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done only while idle
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7: an acknowledged point is followed by a quiet cycle
  assert_gap_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !issue);

  // R6: an issued point stays issued until acknowledged
  assert_issue_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !ack) |=> issue);

endmodule

// File: rtl/glyph_plotter.sv
module glyph_plotter
  import glyph_plot_pkg::*;
#(
  parameter int COLS = 9,
  parameter int ROWS = 14,
  parameter int CW   = 9,
  localparam int IMG_W = COLS * ROWS,
  localparam int CLW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int IW  = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IMG_W-1:0] image_i,
  input  logic [CW-1:0]    base_x_i,
  input  logic [CW-1:0]    base_y_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CW-1:0]    pt_x_o,
  output logic [CW-1:0]    pt_y_o,
  output logic             pt_wr_o,
  output logic             pt_er_o,
  input  logic             pt_ack_i
);

  // Coordinate arithmetic, wrapping at the coordinate width.
  function automatic logic [CW-1:0] col_to_x(logic [CW-1:0] bx, logic [CLW-1:0] c);
    return bx + CW'(c);
  endfunction

  function automatic logic [CW-1:0] row_to_y(logic [CW-1:0] by, logic [RW-1:0] r);
    return by - CW'(r);
  endfunction

  logic [IMG_W-1:0] img_q;
  logic [CW-1:0]    bx_q, by_q;
  logic [CLW-1:0]   col;
  logic [RW-1:0]    row;
  logic [IW-1:0]    idx;
  logic             last, capture, issue, step, dot;

  glyph_cmd_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_i),
    .ack     (pt_ack_i),
    .last    (last),
    .capture (capture),
    .issue   (issue),
    .step    (step),
    .busy    (busy_o),
    .done    (done_o)
  );

  glyph_scan_ctr #(.COLS(COLS), .ROWS(ROWS)) u_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (capture),
    .step  (step),
    .col   (col),
    .row   (row),
    .last  (last)
  );

  assign idx = IW'(dot_index(int'(col), int'(row), ROWS));

  glyph_bit_pick #(.W(IMG_W)) u_pick (
    .image (img_q),
    .idx   (idx),
    .dot   (dot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img_q <= '0;
      bx_q  <= '0;
      by_q  <= '0;
    end else if (capture) begin
      img_q <= image_i;
      bx_q  <= base_x_i;
      by_q  <= base_y_i;
    end
  end

  assign pt_x_o  = col_to_x(bx_q, col);
  assign pt_y_o  = row_to_y(by_q, row);
  assign pt_wr_o = issue && dot;
  assign pt_er_o = issue && !dot;

  // R5: never write and erase together
  assert_wr_er_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pt_wr_o && pt_er_o));

  // R6: the point command holds still until the display acknowledges
  assert_cmd_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pt_wr_o || pt_er_o) && !pt_ack_i) |=>
      ($stable(pt_x_o) && $stable(pt_y_o) && $stable(pt_wr_o) && $stable(pt_er_o)));

  // R9: a start while busy leaves the captured cell untouched
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(img_q) && $stable(bx_q) && $stable(by_q)));

  // R2: start from idle raises busy and presents a point next cycle
  assert_start_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && (pt_wr_o || pt_er_o)));

endmodule

// File: tb/sim_glyph_plotter.sv
module sim_glyph_plotter;

  localparam int COLS = 9;
  localparam int ROWS = 14;
  localparam int NB   = COLS * ROWS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [NB-1:0] image_i = '0;
  logic [8:0]    base_x_i = '0;
  logic [8:0]    base_y_i = '0;
  logic          busy_o, done_o, pt_wr_o, pt_er_o;
  logic [8:0]    pt_x_o, pt_y_o;
  logic          pt_ack_i = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  glyph_plotter u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .image_i  (image_i),
    .base_x_i (base_x_i),
    .base_y_i (base_y_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .pt_x_o   (pt_x_o),
    .pt_y_o   (pt_y_o),
    .pt_wr_o  (pt_wr_o),
    .pt_er_o  (pt_er_o),
    .pt_ack_i (pt_ack_i)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic plot_cell(input logic [NB-1:0] img, input logic [8:0] bx,
                           input logic [8:0] by, input int dly, input bit poke);
    @(negedge clk);
    start_i  = 1'b1;
    image_i  = img;
    base_x_i = bx;
    base_y_i = by;
    @(negedge clk);
    start_i  = 1'b0;
    image_i  = ~img;               // capture must already have happened
    chk(busy_o === 1'b1, "R2 busy after start", {31'd0, busy_o}, 32'd1);
    for (int c = 0; c < COLS; c++) begin
      for (int r = 0; r < ROWS; r++) begin
        logic [8:0] ex, ey;
        bit         b;
        int         w;
        ex = bx + 9'(c);
        ey = by - 9'(r);
        b  = img[c*ROWS + r];
        w  = 0;
        while (!(pt_wr_o || pt_er_o) && w < 8) begin
          @(negedge clk);
          w++;
        end
        // R3 order / R4 coordinates / R5 command kind
        chk(pt_x_o === ex && pt_y_o === ey, "R3 R4 point coordinate",
            {14'd0, pt_x_o, pt_y_o}, {14'd0, ex, ey});
        chk(pt_wr_o === b && pt_er_o === !b, "R5 write/erase from bit",
            {30'd0, pt_wr_o, pt_er_o}, {30'd0, b, !b});
        if (poke && c == 0 && r == 3) begin
          start_i  = 1'b1;
          base_x_i = bx + 9'd7;
          base_y_i = by + 9'd5;
          @(negedge clk);
          start_i  = 1'b0;
          chk(pt_x_o === ex && pt_y_o === ey && pt_wr_o === b,
              "R9 start while busy ignored", {14'd0, pt_x_o, pt_y_o},
              {14'd0, ex, ey});
        end
        for (int d = 0; d < dly; d++) begin
          @(negedge clk);
          chk(pt_x_o === ex && pt_y_o === ey && pt_wr_o === b && pt_er_o === !b,
              "R6 command held", {14'd0, pt_x_o, pt_y_o}, {14'd0, ex, ey});
        end
        pt_ack_i = 1'b1;
        @(negedge clk);
        pt_ack_i = 1'b0;
        if (c == COLS-1 && r == ROWS-1) begin
          chk(done_o === 1'b1 && busy_o === 1'b0 && !pt_wr_o && !pt_er_o,
              "R8 done after last point", {28'd0, done_o, busy_o, pt_wr_o, pt_er_o},
              32'h8);
          @(negedge clk);
          chk(done_o === 1'b0, "R8 done one cycle", {31'd0, done_o}, 32'd0);
        end else begin
          chk(!pt_wr_o && !pt_er_o && busy_o, "R7 gap after ack",
              {29'd0, busy_o, pt_wr_o, pt_er_o}, 32'h4);
        end
      end
    end
  endtask

  initial begin
    logic [NB-1:0] p3, p5, alt;
    for (int i = 0; i < NB; i++) begin
      p3[i]  = (i % 3 == 0);
      p5[i]  = ((i * 7 + 3) % 5) < 2;
      alt[i] = i[0];
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && !pt_wr_o && !pt_er_o, "R1 reset outputs",
        {28'd0, busy_o, done_o, pt_wr_o, pt_er_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !pt_wr_o && !pt_er_o, "R1 idle after reset",
        {28'd0, busy_o, done_o, pt_wr_o, pt_er_o}, 32'd0);
    plot_cell('0,     9'd10,  9'd200, 0, 1'b0);
    plot_cell('1,     9'd505, 9'd5,   1, 1'b0);   // X and Y both wrap
    plot_cell(alt,    9'd0,   9'd0,   2, 1'b1);
    plot_cell(p3,     9'd511, 9'd511, 3, 1'b1);
    plot_cell(p5,     9'd256, 9'd13,  0, 1'b0);
    plot_cell(~p5,    9'd100, 9'd300, 1, 1'b1);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule